// File: doc/BRIEF.md
# Clock Power-Down Sequencer with Strap Capture

This block controls how a clock generator goes into and comes out of its low-power state. An active-low power-down request can arrive at any time, with no relation to the clock. The block passes it through a two-flop synchronizer. It then forces every clock group enable low and keeps them low for a set number of cycles. Only after that does it drop the oscillator and VCO enables. When the request is released, the block turns the oscillators back on straight away. The output enables stay low until a settle counter runs out.

Each group enable changes on the falling edge of the reference clock. This lets a downstream gate stop its clock cleanly in the low phase. The reference-frequency group has its own delay chain, so its stop can trail the other groups by a set number of falling edges. Per-group stop inputs switch single groups off while the block runs normally. They have no effect while a power-down sequence is in progress.

On the first rising edge after power-on reset is released, the block reads the shared strap pins into a latch. It then turns those pins into outputs. One latched bit is the mode strap. When that bit is 1, power-down requests are ignored.

Top module: `pdn_seq`

## Requirements
- R1: A low level on `pd_req_ni` is synchronized by two rising-edge flops. The sequencer moves to its stopping state on the third rising edge after the request is first seen low. All `grp_en_o` bits go low on the falling edge that follows.
- R2: In normal running, `grp_en_o[g]` follows `stop_ni[g]` (1 = run), delayed by two rising edges and one falling edge. While power-down or wake-up is in progress, `stop_ni` has no effect and every group enable is 0.
- R3: `ref_en_o` follows the internal run condition with a lag of `REF_LAG` falling edges. Its stop therefore trails the other groups.
- R4: `osc_en_o` and `vco_en_o` drop only after the stopping state has lasted `REF_LAG + HOLD_CYC` cycles. While they are low, every group enable and `ref_en_o` is 0.
- R5: After `pd_req_ni` returns high in the off state, both oscillator enables rise at once. The outputs stay forced low for `SETTLE_CYC` cycles, and then normal running resumes.
- R6: On the first rising edge after `rst_ni` is released, `strap_i` is captured into `strap_q_o` and `strap_oe_o` goes to 1. It stays at 1 until the next reset.
- R7: After capture, changes on `strap_i` have no effect on `strap_q_o`.
- R8: When bit `MODE_BIT` of the latched strap is 1, a power-down request has no effect: the oscillator enables stay at 1 and the clock groups keep running.
- R9: If the request goes low again during the settle period, the exit is aborted and the block returns to the off state, with the oscillator enables low.
- R10: During reset, all group and reference enables are 0, the oscillator enables are 1, `strap_oe_o` is 0 and `strap_q_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pd_req_ni | input | 1 | Power-down request, active low, asynchronous |
| stop_ni | input | N_GRP | Per-group stop requests, active low, asynchronous |
| strap_i | input | STRAP_W | Strap levels read from the shared pins |
| strap_q_o | output | STRAP_W | Latched strap values |
| strap_oe_o | output | 1 | Direction of the shared pins, 1 = output |
| grp_en_o | output | N_GRP | Clock group enables, 1 = running |
| ref_en_o | output | 1 | Reference-frequency group enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |

## Verification
The bench sets `SETTLE_CYC` to 16 instead of the default 4096. This keeps the whole exit window, and an abort within it, to a few dozen cycles. All other parameters keep their defaults. With `REF_LAG` at 2 and `HOLD_CYC` at 2, the lag of the reference group and the hold before the oscillators drop show up as separate cycles in the per-cycle comparison. A second reset with the mode strap set to 1 exercises the path where power-down is ignored.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAKE = 2'd3
  } pdn_state_e;
endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
  parameter int W = 1,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pdn_strap.sv
module pdn_strap #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] strap_q_o,
  output logic         done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q_o <= '0;
      done_o    <= 1'b0;
    end else if (!done_o) begin
      strap_q_o <= strap_i;
      done_o    <= 1'b1;
    end
  end
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
#(
  parameter int STOP_CYC   = 4,
  parameter int SETTLE_CYC = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_n_i,
  input  logic       honour_i,
  output pdn_state_e state_o
);
  localparam int MAXC = (STOP_CYC > SETTLE_CYC) ? STOP_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STOP_LAST   = CW'(STOP_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  pdn_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: if (!req_n_i && honour_i) begin
        state_d = ST_STOP;
        cnt_d   = '0;
      end
      ST_STOP: if (cnt_q == STOP_LAST) begin
        state_d = ST_OFF;
        cnt_d   = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_OFF: if (req_n_i) begin
        state_d = ST_WAKE;
        cnt_d   = '0;
      end
      ST_WAKE: if (!req_n_i) state_d = ST_OFF;  // abort back to off
      else if (cnt_q == SETTLE_LAST) state_d = ST_RUN;
      else cnt_d = cnt_q + 1'b1;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pdn_gate.sv
module pdn_gate #(
  parameter int N_GRP   = 4,
  parameter int REF_LAG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [N_GRP-1:0] stop_n_i,
  output logic [N_GRP-1:0] grp_en_o,
  output logic             ref_en_o
);
  // enables change on the falling edge so gated clocks stop in the low phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_en_o <= '0;
    else         grp_en_o <= run_i ? stop_n_i : '0;
  end

  logic [REF_LAG-1:0] ref_sh;
  generate
    if (REF_LAG == 1) begin : g_ref1
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ref_sh <= '0;
        else         ref_sh <= run_i;
      end
    end else begin : g_refn
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ref_sh <= '0;
        else         ref_sh <= {ref_sh[REF_LAG-2:0], run_i};
      end
    end
  endgenerate

  assign ref_en_o = ref_sh[REF_LAG-1];
endmodule

// File: rtl/pdn_seq.sv
module pdn_seq
  import pdn_pkg::*;
#(
  parameter int N_GRP      = 4,
  parameter int STRAP_W    = 4,
  parameter int MODE_BIT   = 0,
  parameter int REF_LAG    = 2,
  parameter int HOLD_CYC   = 2,
  parameter int SETTLE_CYC = 4096
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pd_req_ni,
  input  logic [N_GRP-1:0]   stop_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] strap_q_o,
  output logic               strap_oe_o,
  output logic [N_GRP-1:0]   grp_en_o,
  output logic               ref_en_o,
  output logic               osc_en_o,
  output logic               vco_en_o
);
  localparam int STOP_CYC = REF_LAG + HOLD_CYC;

  logic             req_s;
  logic [N_GRP-1:0] stop_s;
  logic             strap_done;
  pdn_state_e       state;

  pdn_sync #(.W(1), .RST_VAL(1'b1)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_req_ni), .q_o(req_s)
  );

  pdn_sync #(.W(N_GRP), .RST_VAL(1'b1)) u_stop_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stop_ni), .q_o(stop_s)
  );

  pdn_strap #(.W(STRAP_W)) u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i),
    .strap_q_o(strap_q_o), .done_o(strap_done)
  );

  pdn_fsm #(.STOP_CYC(STOP_CYC), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_n_i(req_s),
    .honour_i(strap_done && !strap_q_o[MODE_BIT]), .state_o(state)
  );

  pdn_gate #(.N_GRP(N_GRP), .REF_LAG(REF_LAG)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(strap_done && (state == ST_RUN)),
    .stop_n_i(stop_s), .grp_en_o(grp_en_o), .ref_en_o(ref_en_o)
  );

  assign strap_oe_o = strap_done;
  assign osc_en_o   = (state != ST_OFF);
  assign vco_en_o   = (state != ST_OFF);
endmodule

// File: rtl/pdn_seq_chk.sv
module pdn_seq_chk #(
  parameter int N_GRP    = 4,
  parameter int STRAP_W  = 4,
  parameter int MODE_BIT = 0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [STRAP_W-1:0] strap_q_o,
  input logic               strap_oe_o,
  input logic [N_GRP-1:0]   grp_en_o,
  input logic               ref_en_o,
  input logic               osc_en_o,
  input logic               vco_en_o
);
  p_osc_off_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (grp_en_o == '0 && !ref_en_o));

  p_vco_off_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vco_en_o |-> (grp_en_o == '0 && !ref_en_o));

  p_wake_held_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> (grp_en_o == '0 && !ref_en_o));

  p_oe_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_oe_o |=> strap_oe_o);

  p_strap_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_oe_o |=> $stable(strap_q_o));

  p_mode_blocks_pd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_oe_o && strap_q_o[MODE_BIT]) |-> (osc_en_o && vco_en_o));
endmodule

bind pdn_seq pdn_seq_chk #(.N_GRP(N_GRP), .STRAP_W(STRAP_W), .MODE_BIT(MODE_BIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strap_q_o(strap_q_o), .strap_oe_o(strap_oe_o),
  .grp_en_o(grp_en_o), .ref_en_o(ref_en_o), .osc_en_o(osc_en_o), .vco_en_o(vco_en_o)
);

// File: tb/tb_pdn_seq.sv
module tb_pdn_seq;
  localparam int N = 4;
  localparam int SW = 4;
  localparam int LAG = 2;
  localparam int HOLD = 2;
  localparam int SETTLE = 16;
  localparam int STOPC = LAG + HOLD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic [N-1:0] stop_n = '1;
  logic [SW-1:0] strap = 4'b1010;
  logic [SW-1:0] strap_q;
  logic strap_oe, ref_en, osc_en, vco_en;
  logic [N-1:0] grp_en;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;

  always #2 clk = ~clk;  // 250 MHz

  pdn_seq #(.N_GRP(N), .STRAP_W(SW), .MODE_BIT(0), .REF_LAG(LAG),
            .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_ni(req_n), .stop_ni(stop_n),
    .strap_i(strap), .strap_q_o(strap_q), .strap_oe_o(strap_oe),
    .grp_en_o(grp_en), .ref_en_o(ref_en), .osc_en_o(osc_en), .vco_en_o(vco_en)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  // behavioural reference: 0 run, 1 stopping, 2 off, 3 waking
  int m_st = 0, m_cnt = 0;
  bit r1 = 1, r2 = 1;
  bit [N-1:0] s1 = '1, s2 = '1;
  bit [SW-1:0] m_sq = '0;
  bit m_done = 0;
  bit [N-1:0] m_grp = '0;
  bit m_ref = 0;
  bit ref_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; r1 = 1; r2 = 1; s1 = '1; s2 = '1;
      m_sq = '0; m_done = 0;
    end else begin
      case (m_st)
        0: if (m_done && !r2 && !m_sq[0]) begin m_st = 1; m_cnt = 0; end
        1: if (m_cnt == STOPC - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
        2: if (r2) begin m_st = 3; m_cnt = 0; end
        default: if (!r2) m_st = 2;
                 else if (m_cnt == SETTLE - 1) m_st = 0;
                 else m_cnt++;
      endcase
      r2 = r1; r1 = req_n; s2 = s1; s1 = stop_n;
      if (!m_done) begin m_sq = strap; m_done = 1; end
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_grp = '0; m_ref = 0; ref_q.delete();
      for (int i = 0; i < LAG; i++) ref_q.push_back(1'b0);
    end else begin
      bit run;
      run = (m_st == 0) && m_done;
      m_grp = run ? s2 : '0;
      ref_q.push_back(run);
      void'(ref_q.pop_front());
      m_ref = ref_q[0];
    end
  end

  // per-cycle comparison, one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (started) begin
      chk("R1 grp_en", int'(grp_en), int'(m_grp));
      chk("R3 ref_en", int'(ref_en), int'(m_ref));
      chk("R4 osc_en", int'(osc_en), int'(m_st != 2));
      chk("R4 vco_en", int'(vco_en), int'(m_st != 2));
      chk("R6 strap_oe", int'(strap_oe), int'(m_done));
      chk("R6 strap_q", int'(strap_q), int'(m_sq));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(4);
    started = 1;
    chk("R10 grp_en", int'(grp_en), 0);
    chk("R10 ref_en", int'(ref_en), 0);
    chk("R10 osc_en", int'(osc_en), 1);
    chk("R10 strap_oe", int'(strap_oe), 0);
    chk("R10 strap_q", int'(strap_q), 0);
    rst_n = 1'b1;
    cyc(8);
    chk("R6 latched", int'(strap_q), 'ha);
    chk("R6 oe", int'(strap_oe), 1);
    strap = 4'b0101;
    cyc(4);
    chk("R7 ignored", int'(strap_q), 'ha);
    chk("R3 ref running", int'(ref_en), 1);

    stop_n = 4'b0101;
    cyc(5);
    chk("R2 stop pattern", int'(grp_en), 'h5);
    stop_n = 4'b1111;
    cyc(5);
    chk("R2 stop released", int'(grp_en), 'hf);

    req_n = 1'b0;
    cyc(20);
    chk("R4 osc off", int'(osc_en), 0);
    chk("R4 groups low", int'(grp_en), 0);
    stop_n = 4'b0011;
    cyc(4);
    chk("R2 ignored in pd", int'(grp_en), 0);
    stop_n = 4'b1111;

    req_n = 1'b1;
    cyc(8);
    chk("R5 osc back", int'(osc_en), 1);
    chk("R5 held low", int'(grp_en), 0);
    cyc(SETTLE + 4);
    chk("R5 running", int'(grp_en), 'hf);

    req_n = 1'b0;
    cyc(20);
    req_n = 1'b1;
    cyc(8);
    chk("R9 waking", int'(osc_en), 1);
    req_n = 1'b0;
    cyc(5);
    chk("R9 aborted", int'(osc_en), 0);
    chk("R9 groups low", int'(grp_en), 0);
    req_n = 1'b1;
    cyc(SETTLE + 12);
    chk("R9 recovered", int'(grp_en), 'hf);

    rst_n = 1'b0;
    strap = 4'b0011;
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    chk("R8 mode latched", int'(strap_q), 'h3);
    req_n = 1'b0;
    cyc(20);
    chk("R8 osc stays", int'(osc_en), 1);
    chk("R8 groups run", int'(grp_en), 'hf);
    req_n = 1'b1;
    cyc(4);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule